// File: doc/BRIEF.md
# Discontinuous-Mode Conversion Sequencer

This block drives an analog-to-digital converter through a programmable list of up to sixteen channel numbers. A trigger pulse starts a burst. In discontinuous mode the burst covers only the next few entries of the list, and the position in the list is kept between triggers. In full mode the burst runs from the current position to the end of the list. The final burst of a pass stops at the end of the list, and the trigger after that starts again at the first entry.

Channels go to the converter one at a time over a valid/ready request channel. The converter returns each result as a single-cycle valid strobe. The block cannot stall a result, so the result interface has no ready. A request holds its channel number steady while `conv_req_ready` is low. Only one request is outstanding at a time, and the next one is raised only after its result has arrived. Each result lands in one 16-bit data register, which overwrites the previous value. Each result also sets an end-of-conversion flag. A one-cycle pulse marks the end of the whole list.

Top module: `adc_burst_seq`

## Requirements
- R1: After reset, `data_out`, `eoc_flag`, `seq_done`, `busy` and `conv_req_valid` are all 0, and the list position is entry 0.
- R2: With `disc_mode`=1, a trigger converts the next n entries in list order, where n = `burst_cfg`+1 (0 means 1, 7 means 8). The list position carries over to the next trigger.
- R3: The list length is `len_cfg`+1 (1 to 16). A burst that reaches the last entry stops there, even if it is short, and the next trigger starts at entry 0.
- R4: With `disc_mode`=0, a trigger converts every entry from the current position through the last entry.
- R5: `conv_req_valid` stays high with a stable `conv_req_chan` until `conv_req_ready` is sampled high. `conv_req_valid` is low while a result is awaited.
- R6: In the cycle after `conv_res_valid` is sampled, `data_out` holds that result and `eoc_flag` is 1. This happens for every single conversion.
- R7: A one-cycle pulse on `eoc_clr` or on `data_rd` clears `eoc_flag`. If a result arrives in the same cycle, the flag stays set.
- R8: `seq_done` is high for exactly one cycle. That cycle is the one in which the result of the last list entry appears on `data_out`.
- R9: A trigger that arrives while `busy` is high is ignored.
- R10: While `busy` is low, `list_we` stores `list_wdata` into entry `list_waddr`. While `busy` is high, writes are ignored.
- R11: While `enable` is low, any burst is aborted, `busy` and `conv_req_valid` fall in the next cycle, the position returns to entry 0, and triggers are ignored.
- R12: The mode, burst size and length are sampled at the trigger. If the current position lies beyond the new last entry, the burst starts at entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Sequencer enable; low aborts and rewinds |
| disc_mode | input | 1 | 1: burst of n entries; 0: run to end of list |
| burst_cfg | input | 3 | Burst size minus one |
| len_cfg | input | 4 | List length minus one |
| list_we | input | 1 | List write strobe |
| list_waddr | input | 4 | List entry to write |
| list_wdata | input | 5 | Channel number to store |
| trigger | input | 1 | Starts the next burst |
| conv_req_valid | output | 1 | Conversion request valid |
| conv_req_chan | output | 5 | Channel to convert |
| conv_req_ready | input | 1 | Converter accepts the request |
| conv_res_valid | input | 1 | Result strobe from the converter |
| conv_res_data | input | 16 | Conversion result |
| data_out | output | 16 | Data register |
| data_rd | input | 1 | Data register read strobe; clears the flag |
| eoc_clr | input | 1 | Software clear of the flag |
| eoc_flag | output | 1 | End-of-conversion flag |
| seq_done | output | 1 | Last list entry converted (one cycle) |
| busy | output | 1 | A burst is in progress |

## Verification
The bench goes after three groups of cases. The first is the short final burst and the wrap back to entry 0. A design that gets this wrong either reads past the programmed length or resumes mid-list. The second is a list length reduced below the current position. A wrong design would convert stale entries that lie beyond the new end. The third is full mode starting mid-list, where a wrong design restarts at entry 0 or stops early.

The bench also holds `conv_req_ready` low for a while and then writes the entry being requested. If the design broke the handshake, or let the write through, the channel on the request would change. It drops `enable` during a stalled request to check that the position rewinds. A stray trigger while busy would appear as an unexpected extra request. A flag that is set only once per burst, rather than after every conversion, would show up as a missing `eoc_flag` after a conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } seq_state_e;
endpackage

// File: rtl/adc_chan_list.sv
module adc_chan_list #(
  parameter int DEPTH  = 16,
  parameter int CHAN_W = 5,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [CHAN_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_idx,
  output logic [CHAN_W-1:0] rd_chan
);
  wire logic [DEPTH*CHAN_W-1:0] flat;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [CHAN_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              q <= '0;
      else if (wr_en && wr_addr == AW'(g))     q <= wr_data;
    end
    assign flat[g*CHAN_W +: CHAN_W] = q;
  end

  assign rd_chan = flat[rd_idx*CHAN_W +: CHAN_W];
endmodule

// File: rtl/adc_burst_ctrl.sv
module adc_burst_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int BURST_W = 3,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               disc_mode,
  input  logic [BURST_W-1:0] burst_cfg,
  input  logic [AW-1:0]      len_cfg,
  input  logic               trigger,
  input  logic               req_ready,
  input  logic               res_valid,
  output logic               req_valid,
  output logic [AW-1:0]      pos,
  output logic               busy,
  output logic               res_take,
  output logic               seq_done
);
  seq_state_e         state_q, state_d;
  logic [AW-1:0]      pos_q, pos_d;
  logic [AW-1:0]      last_q, last_d;
  logic [BURST_W-1:0] cnt_q, cnt_d;
  logic [BURST_W-1:0] lim_q, lim_d;
  logic               disc_q, disc_d;
  logic               done_q;
  logic               at_end, burst_end;

  assign at_end    = (pos_q == last_q);
  assign burst_end = disc_q && (cnt_q == lim_q);
  assign res_take  = enable && (state_q == ST_WAIT) && res_valid;

  always_comb begin
    state_d = state_q;
    pos_d   = pos_q;
    last_d  = last_q;
    cnt_d   = cnt_q;
    lim_d   = lim_q;
    disc_d  = disc_q;
    unique case (state_q)
      ST_IDLE: begin
        if (trigger) begin
          state_d = ST_REQ;
          cnt_d   = '0;
          lim_d   = burst_cfg;
          last_d  = len_cfg;
          disc_d  = disc_mode;
          if (pos_q > len_cfg) pos_d = '0;
        end
      end
      ST_REQ: begin
        if (req_ready) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (res_valid) begin
          cnt_d   = cnt_q + 1'b1;
          pos_d   = at_end ? '0 : pos_q + 1'b1;
          state_d = (at_end || burst_end) ? ST_IDLE : ST_REQ;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (!enable) begin
      state_d = ST_IDLE;
      pos_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pos_q   <= '0;
      last_q  <= '0;
      cnt_q   <= '0;
      lim_q   <= '0;
      disc_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
      last_q  <= last_d;
      cnt_q   <= cnt_d;
      lim_q   <= lim_d;
      disc_q  <= disc_d;
      done_q  <= res_take && at_end;
    end
  end

  assign req_valid = (state_q == ST_REQ);
  assign busy      = (state_q != ST_IDLE);
  assign pos       = pos_q;
  assign seq_done  = done_q;
endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [DATA_W-1:0] din,
  input  logic              clr,
  input  logic              rd,
  output logic [DATA_W-1:0] dout,
  output logic              flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
      flag <= 1'b0;
    end else begin
      if (take) dout <= din;
      if (take)           flag <= 1'b1;
      else if (clr || rd) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_burst_seq.sv
module adc_burst_seq #(
  parameter int LIST_DEPTH = 16,
  parameter int CHAN_W     = 5,
  parameter int DATA_W     = 16,
  parameter int BURST_W    = 3,
  localparam int AW        = $clog2(LIST_DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               disc_mode,
  input  logic [BURST_W-1:0] burst_cfg,
  input  logic [AW-1:0]      len_cfg,
  input  logic               list_we,
  input  logic [AW-1:0]      list_waddr,
  input  logic [CHAN_W-1:0]  list_wdata,
  input  logic               trigger,
  output logic               conv_req_valid,
  output logic [CHAN_W-1:0]  conv_req_chan,
  input  logic               conv_req_ready,
  input  logic               conv_res_valid,
  input  logic [DATA_W-1:0]  conv_res_data,
  output logic [DATA_W-1:0]  data_out,
  input  logic               data_rd,
  input  logic               eoc_clr,
  output logic               eoc_flag,
  output logic               seq_done,
  output logic               busy
);
  logic [AW-1:0] pos;
  logic          res_take;
  logic          busy_int;

  adc_burst_ctrl #(.DEPTH(LIST_DEPTH), .BURST_W(BURST_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .disc_mode (disc_mode),
    .burst_cfg (burst_cfg),
    .len_cfg   (len_cfg),
    .trigger   (trigger),
    .req_ready (conv_req_ready),
    .res_valid (conv_res_valid),
    .req_valid (conv_req_valid),
    .pos       (pos),
    .busy      (busy_int),
    .res_take  (res_take),
    .seq_done  (seq_done)
  );

  adc_chan_list #(.DEPTH(LIST_DEPTH), .CHAN_W(CHAN_W)) u_list (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (list_we && !busy_int),
    .wr_addr (list_waddr),
    .wr_data (list_wdata),
    .rd_idx  (pos),
    .rd_chan (conv_req_chan)
  );

  adc_result_reg #(.DATA_W(DATA_W)) u_res (
    .clk  (clk),
    .rst_n(rst_n),
    .take (res_take),
    .din  (conv_res_data),
    .clr  (eoc_clr),
    .rd   (data_rd),
    .dout (data_out),
    .flag (eoc_flag)
  );

  assign busy = busy_int;
endmodule

// File: rtl/adc_burst_seq_chk.sv
module adc_burst_seq_chk #(
  parameter int CHAN_W = 5,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              conv_req_valid,
  input logic [CHAN_W-1:0] conv_req_chan,
  input logic              conv_req_ready,
  input logic              conv_res_valid,
  input logic [DATA_W-1:0] conv_res_data,
  input logic [DATA_W-1:0] data_out,
  input logic              data_rd,
  input logic              eoc_clr,
  input logic              eoc_flag,
  input logic              seq_done,
  input logic              busy
);
  logic waiting;
  assign waiting = busy && !conv_req_valid;

  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n || !enable)
    (conv_req_valid && !conv_req_ready) |=> (conv_req_valid && $stable(conv_req_chan)));

  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !conv_req_valid);

  a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_res_valid && waiting && enable) |=> (eoc_flag && data_out == $past(conv_res_data)));

  a_r7_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((eoc_clr || data_rd) && !(conv_res_valid && waiting && enable)) |=> !eoc_flag);

  a_r8_done_width: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done);

  a_r8_done_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> eoc_flag);

  a_r11_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!busy && !conv_req_valid));
endmodule

bind adc_burst_seq adc_burst_seq_chk #(.CHAN_W(CHAN_W), .DATA_W(DATA_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .enable         (enable),
  .conv_req_valid (conv_req_valid),
  .conv_req_chan  (conv_req_chan),
  .conv_req_ready (conv_req_ready),
  .conv_res_valid (conv_res_valid),
  .conv_res_data  (conv_res_data),
  .data_out       (data_out),
  .data_rd        (data_rd),
  .eoc_clr        (eoc_clr),
  .eoc_flag       (eoc_flag),
  .seq_done       (seq_done),
  .busy           (busy)
);

// File: tb/adc_burst_seq_tb_top.sv
module adc_burst_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, enable, disc_mode, list_we, trigger;
  logic [2:0]  burst_cfg;
  logic [3:0]  len_cfg, list_waddr;
  logic [4:0]  list_wdata, conv_req_chan;
  logic        conv_req_valid, conv_req_ready, conv_res_valid;
  logic [15:0] conv_res_data, data_out;
  logic        data_rd, eoc_clr, eoc_flag, seq_done, busy;

  int n_chk = 0;
  int n_bad = 0;
  int exp_chan[$];
  bit exp_last[$];
  bit in_flight = 0;
  bit stall = 0;
  bit done_flag = 0;
  int lst[16];
  int m_pos = 0;
  int last_start = 0;

  adc_burst_seq dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .disc_mode(disc_mode),
    .burst_cfg(burst_cfg), .len_cfg(len_cfg), .list_we(list_we),
    .list_waddr(list_waddr), .list_wdata(list_wdata), .trigger(trigger),
    .conv_req_valid(conv_req_valid), .conv_req_chan(conv_req_chan),
    .conv_req_ready(conv_req_ready), .conv_res_valid(conv_res_valid),
    .conv_res_data(conv_res_data), .data_out(data_out), .data_rd(data_rd),
    .eoc_clr(eoc_clr), .eoc_flag(eoc_flag), .seq_done(seq_done), .busy(busy)
  );

  initial begin
    clk = 0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  // converter model and scoreboard monitor
  initial begin
    int k;
    int ch;
    int ev;
    bit lastx;
    logic [15:0] dv;
    k = 0;
    conv_req_ready = 0;
    conv_res_valid = 0;
    conv_res_data = '0;
    forever begin
      @(negedge clk);
      k++;
      conv_req_ready = !stall && (k % 4 != 2);
      if (conv_req_valid && conv_req_ready) begin
        ch = int'(conv_req_chan);
        in_flight = 1;
        if (exp_chan.size() == 0) begin
          check(0, "R9", "unexpected request chan", ch, -1);
          lastx = 0;
        end else begin
          ev = exp_chan.pop_front();
          lastx = exp_last.pop_front();
          check(ch == ev, "R2", "channel order", ch, ev);
        end
        @(negedge clk);
        conv_req_ready = 0;
        check(!conv_req_valid, "R5", "request while waiting", int'(conv_req_valid), 0);
        @(negedge clk);
        dv = 16'(ch * 16'h0123 + k);
        conv_res_valid = 1;
        conv_res_data = dv;
        @(negedge clk);
        conv_res_valid = 0;
        check(data_out == dv, "R6", "data register", int'(data_out), int'(dv));
        check(eoc_flag, "R6", "flag after conversion", int'(eoc_flag), 1);
        check(seq_done == lastx, "R8", "sequence done", int'(seq_done), int'(lastx));
        @(negedge clk);
        check(!seq_done, "R8", "pulse width", int'(seq_done), 0);
        in_flight = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "R1", "watchdog expired", 0, 1);
    finish_up();
  end

  task automatic pulse_trigger();
    @(negedge clk); trigger = 1;
    @(negedge clk); trigger = 0;
  endtask

  task automatic run_trig();
    int p;
    int c;
    int n;
    int ln;
    n  = int'(burst_cfg) + 1;
    ln = int'(len_cfg);
    p  = (m_pos > ln) ? 0 : m_pos;
    last_start = p;
    c = 0;
    while (1) begin
      exp_chan.push_back(lst[p]);
      exp_last.push_back(p == ln);
      c++;
      if (p == ln) begin p = 0; break; end
      p++;
      if (disc_mode && c == n) break;
    end
    m_pos = p;
    pulse_trigger();
  endtask

  task automatic wait_idle(input string req);
    int guard;
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while ((exp_chan.size() != 0 || in_flight || busy) && guard < 2000);
    repeat (3) @(negedge clk);
    check(!busy && !conv_req_valid, req, "idle after burst", int'(busy), 0);
  endtask

  task automatic wr_list(input int a, input int d);
    @(negedge clk);
    list_we = 1; list_waddr = 4'(a); list_wdata = 5'(d);
    @(negedge clk);
    list_we = 0;
  endtask

  initial begin
    int base[8];
    base = '{0, 1, 2, 3, 6, 7, 9, 10};
    rst_n = 0; enable = 0; disc_mode = 1; burst_cfg = 3'd2; len_cfg = 4'd7;
    list_we = 0; list_waddr = 0; list_wdata = 0; trigger = 0;
    data_rd = 0; eoc_clr = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(data_out == 0, "R1", "data after reset", int'(data_out), 0);
    check(!eoc_flag, "R1", "flag after reset", int'(eoc_flag), 0);
    check(!seq_done && !busy && !conv_req_valid, "R1", "control after reset",
          int'(busy), 0);
    rst_n = 1;
    for (int i = 0; i < 16; i++) begin
      lst[i] = (i < 8) ? base[i] : 16 + i;
      wr_list(i, lst[i]);
    end
    enable = 1;

    // R2, R3, R8: bursts of 3 over 8 entries, short final burst, wrap
    for (int t = 0; t < 4; t++) begin
      run_trig();
      wait_idle("R3");
    end

    // R7: software clear
    check(eoc_flag, "R7", "flag set before clear", int'(eoc_flag), 1);
    @(negedge clk); eoc_clr = 1; @(negedge clk); eoc_clr = 0;
    check(!eoc_flag, "R7", "clear strobe", int'(eoc_flag), 0);

    // R9: second trigger during a burst is ignored
    run_trig();
    pulse_trigger();
    wait_idle("R9");
    check(eoc_flag, "R6", "flag set again", int'(eoc_flag), 1);
    @(negedge clk); data_rd = 1; @(negedge clk); data_rd = 0;
    check(!eoc_flag, "R7", "read strobe clears", int'(eoc_flag), 0);

    // R2/R3 with n=8 over 16 entries, then n=1
    len_cfg = 4'd15; burst_cfg = 3'd7;
    run_trig(); wait_idle("R2");
    run_trig(); wait_idle("R3");
    run_trig(); wait_idle("R2");
    burst_cfg = 3'd0;
    run_trig(); wait_idle("R2");

    // R4: full mode from mid-list
    len_cfg = 4'd7; burst_cfg = 3'd2;
    m_pos = (m_pos > 7) ? 0 : m_pos;
    disc_mode = 0;
    run_trig(); wait_idle("R4");
    disc_mode = 1;
    run_trig(); wait_idle("R2");
    disc_mode = 0;
    run_trig(); wait_idle("R4");
    disc_mode = 1;

    // R12: length shrunk below current position
    run_trig(); wait_idle("R2");
    len_cfg = 4'd1;
    run_trig(); wait_idle("R12");
    check(last_start == 0, "R12", "bench start index", last_start, 0);
    len_cfg = 4'd7;

    // R5, R10, R11: stalled request, write ignored, abort
    stall = 1;
    run_trig();
    repeat (3) @(negedge clk);
    check(conv_req_valid, "R5", "held request", int'(conv_req_valid), 1);
    check(int'(conv_req_chan) == lst[last_start], "R5", "held channel",
          int'(conv_req_chan), lst[last_start]);
    wr_list(last_start, 31);
    check(int'(conv_req_chan) == lst[last_start], "R10", "write while busy ignored",
          int'(conv_req_chan), lst[last_start]);
    @(negedge clk); enable = 0;
    @(negedge clk);
    check(!busy && !conv_req_valid, "R11", "abort", int'(busy), 0);
    pulse_trigger();
    @(negedge clk);
    check(!busy, "R11", "trigger while disabled", int'(busy), 0);
    exp_chan.delete(); exp_last.delete();
    m_pos = 0;
    enable = 1; stall = 0;
    run_trig(); wait_idle("R11");

    // R10: write while idle takes effect
    wr_list(3, 21); lst[3] = 21;
    run_trig(); wait_idle("R10");
    run_trig(); wait_idle("R10");

    repeat (5) @(negedge clk);
    finish_up();
  end
endmodule